// File: doc/BRIEF.md
# Serial Transmit Start Trigger

This block decides the system-clock cycle in which a synchronous serial transmitter may begin shifting out its next word. A 4-bit start mode picks one of eight conditions. The transmitter can start continuously whenever a word waits, on the receiver's own start event, or on a level, an edge or a change of a frame-sync input. Codes above seven are reserved. When the condition is met, the block emits a single-cycle start pulse.

The block also picks the transmit clock from three candidates: the internally divided clock, the receive clock and the transmit clock pin. It synchronizes that clock into the system domain and emits a one-cycle launch strobe on the edge that launches data and frame sync. An inversion bit chooses which edge that is. A separate 3-bit field says whether the clock pin is driven with a continuous transmit clock or left as an input.

Top module: `tx_start_trigger`

## Requirements
- R1: After reset is released, start_pulse and launch_strobe are low, and they stay low while tx_en is low and the clock inputs are still.
- R2: clk_sel chooses the clock source: 0 is div_clk, 1 is rx_clk, 2 is tx_clk_pin. Transitions on a clock input that is not selected produce no launch_strobe.
- R3: With launch_inv = 0, a falling edge of the selected clock gives exactly one launch_strobe cycle and a rising edge gives none. With launch_inv = 1, it is the other way round.
- R4: clk_drive_en is high only when clk_out_mode = 1. Codes 0 and 2 to 7 leave it low.
- R5: Mode 0 (continuous) starts whenever tx_en is high, a word is pending and the transmitter is idle. When xfer_done is sampled high with another word pending, start_pulse follows on the next clock, so back-to-back transfers with a 3-cycle busy model start every 4 cycles.
- R6: Mode 1 gives one start per rx_start_evt pulse sampled while the transmitter is ready.
- R7: Modes 2 and 3 start on a low and on a high synchronized frame-sync level. One start is issued per pending word, and there is none while a transfer is in progress.
- R8: Modes 4 and 5 start once per falling and once per rising frame-sync edge, respectively.
- R9: Mode 6 compares frame sync only at launch strobes and starts once per detected change. It starts nothing while no strobe occurs. Mode 7 starts once per frame-sync edge, compared every system clock.
- R10: Start modes 8 to 15 and clk_sel = 3 are reserved. They produce no start_pulse, and clk_sel = 3 also produces no launch_strobe.
- R11: start_pulse is never high for two cycles in a row. It is never issued while tx_en is low, and never issued while tx_busy is high without xfer_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_mode | input | 4 | Start condition code (0 to 7 valid, 8 to 15 reserved) |
| clk_sel | input | 2 | Transmit clock source code (3 reserved) |
| launch_inv | input | 1 | 0: launch on falling edge, 1: launch on rising edge |
| clk_out_mode | input | 3 | 1: drive continuous clock on pin, 0: pin is input, others reserved |
| div_clk | input | 1 | Internally divided clock |
| rx_clk | input | 1 | Receive clock |
| tx_clk_pin | input | 1 | Clock sampled from the transmit clock pin |
| fsync_in | input | 1 | Asynchronous frame-sync input |
| rx_start_evt | input | 1 | Receiver start event, system domain |
| tx_en | input | 1 | Transmit enable |
| word_pending | input | 1 | A word waits in the holding register |
| tx_busy | input | 1 | Transmitter is shifting a word |
| xfer_done | input | 1 | Last cycle of the current transfer |
| start_pulse | output | 1 | One-cycle start request |
| launch_strobe | output | 1 | One-cycle launch-edge strobe |
| clk_drive_en | output | 1 | Drive the transmit clock out on the pin |

## Verification
The start decision and the end of the running transfer can fall in the same cycle. When xfer_done is high while another word is pending, the block must issue the next start at once, and the busy gate must not swallow it. The bench provokes this with a transmitter model that holds busy for a fixed time and raises xfer_done in its last cycle. It then checks that every gap between starts equals the busy length plus one cycle, and that no start lands in a busy cycle without xfer_done. A second case is a mode 6 frame-sync change and a launch strobe landing together. It is judged by running mode 6 once with the divided clock and once with it stopped.

// File: rtl/tst_pkg.sv
package tst_pkg;
  localparam int MODE_W = 4;
  localparam int CKS_W  = 2;
  localparam int CKO_W  = 3;
  localparam int NUM_SRC = 3;

  localparam logic [MODE_W-1:0] SM_CONT     = 4'd0;
  localparam logic [MODE_W-1:0] SM_RX       = 4'd1;
  localparam logic [MODE_W-1:0] SM_FS_LOW   = 4'd2;
  localparam logic [MODE_W-1:0] SM_FS_HIGH  = 4'd3;
  localparam logic [MODE_W-1:0] SM_FS_FALL  = 4'd4;
  localparam logic [MODE_W-1:0] SM_FS_RISE  = 4'd5;
  localparam logic [MODE_W-1:0] SM_FS_CHG   = 4'd6;
  localparam logic [MODE_W-1:0] SM_FS_EDGE  = 4'd7;

  function automatic logic mode_valid(input logic [MODE_W-1:0] m);
    return m < 4'd8;
  endfunction

  function automatic logic src_valid(input logic [CKS_W-1:0] c);
    return c < 2'(NUM_SRC);
  endfunction

  function automatic logic launch_edge(input logic cur, input logic prev, input logic inv);
    return inv ? (cur & ~prev) : (~cur & prev);
  endfunction

  function automatic logic drives_pin(input logic [CKO_W-1:0] c);
    return c == 3'd1;
  endfunction
endpackage

// File: rtl/tst_sync.sv
module tst_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tst_launch_edge.sv
module tst_launch_edge
  import tst_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_sync,
  input  logic [CKS_W-1:0]   clk_sel,
  input  logic               launch_inv,
  output logic               sel_now,
  output logic               sel_prev,
  output logic               strobe
);
  always_comb begin
    sel_now = 1'b0;
    if (src_valid(clk_sel)) sel_now = src_sync[clk_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_prev <= 1'b0;
    else        sel_prev <= sel_now;
  end

  assign strobe = src_valid(clk_sel) & launch_edge(sel_now, sel_prev, launch_inv);
endmodule

// File: rtl/tst_start_cond.sv
module tst_start_cond
  import tst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              fs_now,
  input  logic              launch_strobe,
  input  logic              rx_evt,
  input  logic              ready,
  input  logic              src_ok,
  output logic              trig,
  output logic              fs_rise,
  output logic              fs_fall,
  output logic              fs_chg_marked
);
  logic fs_prev;
  logic fs_mark;
  logic cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev <= 1'b0;
      fs_mark <= 1'b0;
    end else begin
      fs_prev <= fs_now;
      if (launch_strobe) fs_mark <= fs_now;
    end
  end

  assign fs_rise       = fs_now & ~fs_prev;
  assign fs_fall       = ~fs_now & fs_prev;
  assign fs_chg_marked = launch_strobe & (fs_now ^ fs_mark);

  always_comb begin
    unique case (mode)
      SM_CONT:    cond = 1'b1;
      SM_RX:      cond = rx_evt;
      SM_FS_LOW:  cond = ~fs_now;
      SM_FS_HIGH: cond = fs_now;
      SM_FS_FALL: cond = fs_fall;
      SM_FS_RISE: cond = fs_rise;
      SM_FS_CHG:  cond = fs_chg_marked;
      SM_FS_EDGE: cond = fs_rise | fs_fall;
      default:    cond = 1'b0;
    endcase
  end

  assign trig = ready & src_ok & mode_valid(mode) & cond;
endmodule

// File: rtl/tx_start_trigger.sv
module tx_start_trigger
  import tst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] start_mode,
  input  logic [CKS_W-1:0]  clk_sel,
  input  logic              launch_inv,
  input  logic [CKO_W-1:0]  clk_out_mode,
  input  logic              div_clk,
  input  logic              rx_clk,
  input  logic              tx_clk_pin,
  input  logic              fsync_in,
  input  logic              rx_start_evt,
  input  logic              tx_en,
  input  logic              word_pending,
  input  logic              tx_busy,
  input  logic              xfer_done,
  output logic              start_pulse,
  output logic              launch_strobe,
  output logic              clk_drive_en
);
  localparam int SYNC_W = NUM_SRC + 1;

  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] sync_out;
  logic              sel_now;
  logic              sel_prev;
  logic              src_ok;
  logic              mode_ok;
  logic              tx_ready;
  logic              trig;
  logic              fs_rise;
  logic              fs_fall;
  logic              fs_chg_marked;

  assign raw_in = {fsync_in, tx_clk_pin, rx_clk, div_clk};

  tst_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  tst_launch_edge u_edge (
    .clk(clk), .rst_n(rst_n),
    .src_sync(sync_out[NUM_SRC-1:0]),
    .clk_sel(clk_sel), .launch_inv(launch_inv),
    .sel_now(sel_now), .sel_prev(sel_prev), .strobe(launch_strobe)
  );

  assign src_ok   = src_valid(clk_sel);
  assign mode_ok  = mode_valid(start_mode);
  assign tx_ready = tx_en & word_pending & (~tx_busy | xfer_done) & ~start_pulse;

  tst_start_cond u_cond (
    .clk(clk), .rst_n(rst_n), .mode(start_mode),
    .fs_now(sync_out[NUM_SRC]), .launch_strobe(launch_strobe),
    .rx_evt(rx_start_evt), .ready(tx_ready), .src_ok(src_ok),
    .trig(trig), .fs_rise(fs_rise), .fs_fall(fs_fall),
    .fs_chg_marked(fs_chg_marked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_pulse <= 1'b0;
    else        start_pulse <= trig;
  end

  assign clk_drive_en = drives_pin(clk_out_mode);
endmodule

// File: rtl/tst_checker.sv
module tst_checker (
  input logic clk,
  input logic rst_n,
  input logic start_pulse,
  input logic launch_strobe,
  input logic src_ok,
  input logic mode_ok,
  input logic tx_en,
  input logic tx_busy,
  input logic xfer_done
);
  assert_start_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !xfer_done) |=> !start_pulse);

  assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !start_pulse);

  assert_mode_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ok |=> !start_pulse);

  assert_src_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !src_ok |-> !launch_strobe);

  assert_src_reserved_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !src_ok |=> !start_pulse);

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_strobe |=> !launch_strobe);
endmodule

bind tx_start_trigger tst_checker i_chk (
  .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse),
  .launch_strobe(launch_strobe), .src_ok(src_ok), .mode_ok(mode_ok),
  .tx_en(tx_en), .tx_busy(tx_busy), .xfer_done(xfer_done)
);

// File: tb/test_tx_start_trigger.sv
`timescale 1ns/1ps
module test_tx_start_trigger;
  localparam int LEN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] start_mode = 4'd0;
  logic [1:0] clk_sel = 2'd0;
  logic launch_inv = 1'b0;
  logic [2:0] clk_out_mode = 3'd0;
  logic div_manual = 1'b0, div_auto = 1'b0, div_run = 1'b0;
  logic rx_clk = 1'b0, tx_clk_pin = 1'b0, fsync_in = 1'b0;
  logic rx_start_evt = 1'b0, tx_en = 1'b0;
  logic busy = 1'b0, done = 1'b0, prev_start = 1'b0;
  logic start_pulse, launch_strobe, clk_drive_en;
  logic div_clk, word_pending;
  int words = 0, cnt = 0, div_cnt = 0, cyc = 0;
  int start_cnt = 0, strb_cnt = 0, dbl_err = 0, busy_err = 0;
  int last_start = -1, iv_min = 1000, iv_max = 0;
  int checks = 0, failures = 0;
  bit finished = 0;

  assign div_clk = div_run ? div_auto : div_manual;
  assign word_pending = words > 0;

  tx_start_trigger i_tx_start_trigger (
    .clk(clk), .rst_n(rst_n), .start_mode(start_mode), .clk_sel(clk_sel),
    .launch_inv(launch_inv), .clk_out_mode(clk_out_mode), .div_clk(div_clk),
    .rx_clk(rx_clk), .tx_clk_pin(tx_clk_pin), .fsync_in(fsync_in),
    .rx_start_evt(rx_start_evt), .tx_en(tx_en), .word_pending(word_pending),
    .tx_busy(busy), .xfer_done(done), .start_pulse(start_pulse),
    .launch_strobe(launch_strobe), .clk_drive_en(clk_drive_en)
  );

  always #4 clk = ~clk;

  // monitor and transmitter model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (div_run) begin
      div_cnt++;
      if (div_cnt == 4) begin div_cnt = 0; div_auto = ~div_auto; end
    end
    if (launch_strobe) strb_cnt++;
    if (start_pulse) begin
      start_cnt++;
      if (prev_start) dbl_err++;
      if (busy && !done) busy_err++;
      if (last_start >= 0) begin
        if (cyc - last_start < iv_min) iv_min = cyc - last_start;
        if (cyc - last_start > iv_max) iv_max = cyc - last_start;
      end
      last_start = cyc;
      busy = 1'b1; done = 1'b0; cnt = LEN;
      if (words > 0) words--;
    end else if (busy) begin
      if (done) begin busy = 1'b0; done = 1'b0; end
      else if (cnt == 1) done = 1'b1;
      else cnt--;
    end
    prev_start = start_pulse;
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_counts();
    start_cnt = 0; strb_cnt = 0; last_start = -1; iv_min = 1000; iv_max = 0;
  endtask

  // fixed frame-sync level, three words queued
  task automatic run_level(input int mode, input bit fs, input bit en, input int cks, output int got);
    @(negedge clk);
    tx_en = 1'b0; words = 0; start_mode = 4'(mode); clk_sel = 2'(cks); fsync_in = fs;
    settle(20);
    clear_counts();
    words = 3; tx_en = en;
    settle(60);
    tx_en = 1'b0;
    settle(10);
    got = start_cnt;
    words = 0;
  endtask

  // four frame-sync toggles starting from low
  task automatic run_edges(input int mode, input int cks, input bit div_on, output int got);
    @(negedge clk);
    tx_en = 1'b0; words = 0; start_mode = 4'(mode); clk_sel = 2'(cks);
    fsync_in = 1'b0; div_run = div_on;
    settle(24);
    clear_counts();
    words = 10; tx_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      settle(24);
      fsync_in = ~fsync_in;
    end
    settle(24);
    tx_en = 1'b0;
    settle(10);
    got = start_cnt;
    words = 0; div_run = 1'b1;
  endtask

  task automatic run_rx(input int mode, output int got);
    @(negedge clk);
    tx_en = 1'b0; words = 0; start_mode = 4'(mode); clk_sel = 2'd0; fsync_in = 1'b0;
    settle(20);
    clear_counts();
    words = 10; tx_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      settle(20);
      rx_start_evt = 1'b1;
      @(negedge clk);
      rx_start_evt = 1'b0;
    end
    settle(20);
    tx_en = 1'b0;
    settle(10);
    got = start_cnt;
    words = 0;
  endtask

  task automatic set_src(input int idx, input bit v);
    case (idx)
      0: div_manual = v;
      1: rx_clk = v;
      default: tx_clk_pin = v;
    endcase
  endtask

  task automatic run_strobe(input int cks, input bit inv);
    bit valid;
    int exp_rise, exp_fall;
    valid = (cks != 3);
    exp_rise = (valid && inv) ? 1 : 0;
    exp_fall = (valid && !inv) ? 1 : 0;
    @(negedge clk);
    div_run = 1'b0; tx_en = 1'b0; clk_sel = 2'(cks); launch_inv = inv;
    div_manual = 1'b0; rx_clk = 1'b0; tx_clk_pin = 1'b0;
    settle(10);
    strb_cnt = 0;
    for (int s = 0; s < 3; s++) if (s != cks) set_src(s, 1'b1);
    settle(10);
    check("R2", strb_cnt, 0, $sformatf("unselected sources cks=%0d inv=%0d", cks, inv));
    for (int s = 0; s < 3; s++) if (s != cks) set_src(s, 1'b0);
    settle(10);
    strb_cnt = 0;
    if (valid) set_src(cks, 1'b1);
    else for (int s = 0; s < 3; s++) set_src(s, 1'b1);
    settle(10);
    check(valid ? "R3" : "R10", strb_cnt, exp_rise, $sformatf("rising cks=%0d inv=%0d", cks, inv));
    strb_cnt = 0;
    if (valid) set_src(cks, 1'b0);
    else for (int s = 0; s < 3; s++) set_src(s, 1'b0);
    settle(10);
    check(valid ? "R3" : "R10", strb_cnt, exp_fall, $sformatf("falling cks=%0d inv=%0d", cks, inv));
  endtask

  function automatic int level_expect(input int mode, input bit fs);
    if (mode == 0) return 3;
    if (mode == 2 && !fs) return 3;
    if (mode == 3 && fs) return 3;
    return 0;
  endfunction

  function automatic int edge_expect(input int mode, input bit div_on);
    case (mode)
      4, 5: return 2;
      6: return div_on ? 4 : 0;
      7: return 4;
      default: return 0;
    endcase
  endfunction

  initial begin
    int got;
    settle(3);
    rst_n = 1'b1;
    settle(5);
    check("R1", start_pulse, 0, "start_pulse after reset");
    check("R1", launch_strobe, 0, "launch_strobe after reset");

    for (int c = 0; c < 8; c++) begin
      clk_out_mode = 3'(c);
      #1;
      check("R4", clk_drive_en, (c == 1) ? 1 : 0, $sformatf("clk_out_mode=%0d", c));
    end

    for (int cks = 0; cks < 4; cks++)
      for (int inv = 0; inv < 2; inv++) run_strobe(cks, inv[0]);

    div_run = 1'b1;
    launch_inv = 1'b0;
    for (int fs = 0; fs < 2; fs++)
      for (int m = 0; m < 16; m++) begin
        run_level(m, fs[0], 1'b1, 0, got);
        check(m == 0 ? "R5" : (m < 4 ? "R7" : (m < 8 ? "R9" : "R10")), got,
              level_expect(m, fs[0]), $sformatf("level run mode=%0d fs=%0d", m, fs));
      end

    run_level(0, 1'b0, 1'b1, 0, got);
    check("R5", iv_min, LEN + 1, "shortest back-to-back start gap");
    check("R5", iv_max, LEN + 1, "longest back-to-back start gap");
    run_level(0, 1'b0, 1'b0, 0, got);
    check("R11", got, 0, "no start with tx_en low");
    run_level(0, 1'b0, 1'b1, 3, got);
    check("R10", got, 0, "reserved clock source blocks starts");

    for (int m = 4; m < 16; m++) begin
      run_edges(m, 0, 1'b1, got);
      check(m < 6 ? "R8" : (m < 8 ? "R9" : "R10"), got, edge_expect(m, 1'b1),
            $sformatf("edge run mode=%0d", m));
    end
    run_edges(6, 0, 1'b0, got);
    check("R9", got, 0, "mode 6 without launch strobes");
    run_edges(7, 0, 1'b0, got);
    check("R9", got, 4, "mode 7 without launch strobes");
    run_edges(7, 3, 1'b1, got);
    check("R10", got, 0, "mode 7 with reserved clock source");

    run_rx(1, got);
    check("R6", got, 3, "receiver start events");
    run_rx(9, got);
    check("R10", got, 0, "reserved mode ignores receiver events");

    check("R11", dbl_err, 0, "start pulses in consecutive cycles");
    check("R11", busy_err, 0, "start pulses while busy");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule